// File: doc/BRIEF.md
# Logic Analyzer Capture Controller

This block records a parallel group of digital probe lines into an on-chip sample store and returns the recorded samples to a host as readable text. The host talks to it via single ASCII characters, which arrive as bytes from an external UART receiver over a valid/ready handshake. The host chooses the sampling interval as a clock divisor and chooses how many samples to take. It then arms a capture and, once the done flag is up, requests a dump.

While a capture runs, a programmable divider produces a one-cycle sample strobe. Each strobe writes the probe value at a write address that advances by one. When the last requested sample is written, capture stops and the done flag rises. A dump walks a separate read address over the stored samples. For each sample it sends two uppercase hexadecimal digits and then a line feed, through a valid/ready byte handshake toward an external UART transmitter.

With a 50 MHz system clock, a divisor from 4 up to 50,000,000 spans roughly 12.5 MHz down to 1 Hz. The store holds up to 4096 samples.

Top module: `la_capture_ctrl`

## Requirements
- R1: After reset the block is idle. `done_o` is 0, `tx_valid_o` is 0 and `rx_ready_o` is 1. The divisor defaults to 4 and the sample count defaults to 16.
- R2: The byte 0x52 ('R') followed by exactly 8 hex digit characters, most significant digit first, loads a new divisor. Digit characters are 0x30-0x39 and 0x41-0x46. A loaded value below 4 is stored as 4.
- R3: The byte 0x4E ('N') followed by exactly 3 hex digit characters, most significant digit first, loads the sample count minus one. "000" selects 1 sample and "FFF" selects 4096.
- R4: The byte 0x41 ('A'), received while idle or done, clears `done_o` and starts a capture. With divisor N, sample k (counting from 0) is the probe value at the (k+1)*N-th rising clock edge after the edge that accepted the arm byte. No two sample strobes fall on adjacent cycles.
- R5: A capture of C samples ends on the edge that writes sample C-1, and `done_o` rises on that same edge. `done_o` then stays 1 until a dump or a new arm is accepted.
- R6: Bytes received during a capture, including an arm byte, are consumed and have no effect. This includes an arm byte accepted on the very edge that writes the final sample.
- R7: Any character other than a hex digit, received while a parameter string is being collected, returns the block to idle and leaves the divisor and count unchanged. A character that is not a command, received while idle, is ignored.
- R8: The byte 0x44 ('D'), received while `done_o` is 1, clears `done_o` and starts a dump. The dump covers samples 0 through C-1 in address order. Each sample is sent as three bytes: the uppercase ASCII hex digit of bits 7:4, then that of bits 3:0, then 0x0A. After the last byte the block is idle. A 'D' received while `done_o` is 0 sends nothing.
- R9: While `tx_valid_o` is 1 and `tx_ready_i` is 0, `tx_valid_o` and `tx_data_o` hold their values. `rx_ready_o` is 0 for the whole dump.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| probe_i | input | 8 | Probe lines being sampled |
| rx_valid_i | input | 1 | Received command byte is valid |
| rx_data_i | input | 8 | Received command byte |
| rx_ready_o | output | 1 | Block accepts a received byte |
| tx_valid_o | output | 1 | Outgoing text byte is valid |
| tx_data_o | output | 8 | Outgoing text byte |
| tx_ready_i | input | 1 | Transmitter accepts the outgoing byte |
| done_o | output | 1 | A completed capture is waiting to be read |

## Verification
Two of this block's functions can fall in the same cycle: accepting a command byte, and writing the final sample that ends a capture. The bench provokes this by timing an arm byte so that it is accepted on exactly the edge that writes the last sample. It then judges the result in two ways: `done_o` must rise and stay high instead of a fresh capture starting, and the dump that follows must contain the original sample timeline. A second overlap is a transmitter stall arriving while the dump engine advances between samples. The bench drives a random `tx_ready_i` and requires every stalled byte to be held unchanged.

// File: rtl/la_pkg.sv
package la_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CONFIG,
        ST_CAPTURE,
        ST_DONE,
        ST_READOUT
    } la_state_e;

    localparam logic [7:0] CH_RATE  = 8'h52;
    localparam logic [7:0] CH_COUNT = 8'h4E;
    localparam logic [7:0] CH_ARM   = 8'h41;
    localparam logic [7:0] CH_DUMP  = 8'h44;
    localparam logic [7:0] CH_LF    = 8'h0A;

    function automatic logic is_hex_char(input logic [7:0] c);
        return ((c >= 8'h30) && (c <= 8'h39)) || ((c >= 8'h41) && (c <= 8'h46));
    endfunction

    function automatic logic [3:0] hex_value(input logic [7:0] c);
        logic [7:0] v;
        v = (c <= 8'h39) ? (c - 8'h30) : (c - 8'h37);
        return v[3:0];
    endfunction

    function automatic logic [7:0] nibble_char(input logic [3:0] n);
        return (n < 4'd10) ? (8'h30 + {4'h0, n}) : (8'h37 + {4'h0, n});
    endfunction

endpackage

// File: rtl/la_rate_gen.sv
module la_rate_gen #(
    parameter int DIV_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);

    logic [DIV_W-1:0] cnt_d, cnt_q;

    assign tick_o = run_i && (cnt_q == (div_i - DIV_W'(1)));

    always_comb begin
        cnt_d = cnt_q;
        if (!run_i || tick_o) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + DIV_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // R4: the divisor is never below 4, so strobes are never back to back
    p_tick_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);

endmodule

// File: rtl/la_sample_buf.sv
module la_sample_buf #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [ADDR_W-1:0] raddr_i,
    output logic [DATA_W-1:0] rdata_o
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (we_i) begin
            mem[waddr_i] <= wdata_i;
        end
        rdata_q <= mem[raddr_i];
    end

    assign rdata_o = rdata_q;

endmodule

// File: rtl/la_capture_ctrl.sv
module la_capture_ctrl
    import la_pkg::*;
#(
    parameter int SAMPLE_W    = 8,
    parameter int ADDR_W      = 12,
    parameter int DIV_W       = 32,
    parameter int MIN_DIV     = 4,
    parameter int RESET_DIV   = 4,
    parameter int RESET_COUNT = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SAMPLE_W-1:0] probe_i,
    input  logic                rx_valid_i,
    input  logic [7:0]          rx_data_i,
    output logic                rx_ready_o,
    output logic                tx_valid_o,
    output logic [7:0]          tx_data_o,
    input  logic                tx_ready_i,
    output logic                done_o
);

    localparam int DIV_DIGITS = (DIV_W + 3) / 4;
    localparam int CNT_DIGITS = (ADDR_W + 3) / 4;
    localparam int SMP_DIGITS = (SAMPLE_W + 3) / 4;
    localparam int MAX_DIGITS = (DIV_DIGITS > CNT_DIGITS) ? DIV_DIGITS : CNT_DIGITS;
    localparam int SH_W       = 4 * MAX_DIGITS;
    localparam int DIG_W      = $clog2(MAX_DIGITS + 1);
    localparam int LF_PHASE   = SMP_DIGITS + 1;
    localparam int PH_W       = $clog2(LF_PHASE + 1);
    localparam int PAD_W      = 4 * SMP_DIGITS;

    typedef struct packed {
        la_state_e         state;
        logic              done;
        logic [DIV_W-1:0]  div;
        logic [ADDR_W-1:0] cnt_m1;
        logic [ADDR_W-1:0] last;
        logic              cfg_rate;
        logic [DIG_W-1:0]  digs;
        logic [SH_W-1:0]   sh;
        logic [ADDR_W-1:0] wr;
        logic [ADDR_W-1:0] rd;
        logic [PH_W-1:0]   ph;
    } ctl_t;

    ctl_t d, q;

    logic                tick;
    logic                rx_fire;
    logic [SH_W-1:0]     shifted;
    logic [DIV_W-1:0]    div_new;
    logic [SAMPLE_W-1:0] rd_data;
    logic [PAD_W-1:0]    rd_pad;
    logic [3:0]          nib;

    la_rate_gen #(
        .DIV_W (DIV_W)
    ) u_rate (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (q.state == ST_CAPTURE),
        .div_i  (q.div),
        .tick_o (tick)
    );

    la_sample_buf #(
        .DATA_W (SAMPLE_W),
        .ADDR_W (ADDR_W)
    ) u_buf (
        .clk     (clk),
        .we_i    (tick),
        .waddr_i (q.wr),
        .wdata_i (probe_i),
        .raddr_i (q.rd),
        .rdata_o (rd_data)
    );

    assign rx_ready_o = (q.state != ST_READOUT);
    assign rx_fire    = rx_valid_i && rx_ready_o;
    assign shifted    = {q.sh[SH_W-5:0], hex_value(rx_data_i)};
    assign div_new    = DIV_W'(shifted);
    assign done_o     = q.done;

    // dump byte formatter: phase 1..SMP_DIGITS are digits, LF_PHASE is line feed
    assign rd_pad     = PAD_W'(rd_data);
    assign nib        = 4'(rd_pad >> (4 * (SMP_DIGITS - int'(q.ph))));
    assign tx_valid_o = (q.state == ST_READOUT) && (q.ph != '0);
    assign tx_data_o  = (int'(q.ph) == LF_PHASE) ? CH_LF : nibble_char(nib);

    always_comb begin
        d = q;
        unique case (q.state)
            ST_IDLE, ST_DONE: begin
                if (rx_fire) begin
                    if (rx_data_i == CH_RATE) begin
                        d.state    = ST_CONFIG;
                        d.cfg_rate = 1'b1;
                        d.digs     = '0;
                        d.sh       = '0;
                    end else if (rx_data_i == CH_COUNT) begin
                        d.state    = ST_CONFIG;
                        d.cfg_rate = 1'b0;
                        d.digs     = '0;
                        d.sh       = '0;
                    end else if (rx_data_i == CH_ARM) begin
                        d.state = ST_CAPTURE;
                        d.done  = 1'b0;
                        d.wr    = '0;
                        d.last  = q.cnt_m1;
                    end else if ((rx_data_i == CH_DUMP) && q.done) begin
                        d.state = ST_READOUT;
                        d.done  = 1'b0;
                        d.rd    = '0;
                        d.ph    = '0;
                    end else begin
                        d.state = ST_IDLE;
                    end
                end
            end
            ST_CONFIG: begin
                if (rx_fire) begin
                    if (is_hex_char(rx_data_i)) begin
                        d.sh   = shifted;
                        d.digs = q.digs + DIG_W'(1);
                        if (q.cfg_rate && (q.digs == DIG_W'(DIV_DIGITS - 1))) begin
                            d.div   = (div_new < DIV_W'(MIN_DIV)) ? DIV_W'(MIN_DIV) : div_new;
                            d.state = ST_IDLE;
                        end else if (!q.cfg_rate && (q.digs == DIG_W'(CNT_DIGITS - 1))) begin
                            d.cnt_m1 = ADDR_W'(shifted);
                            d.state  = ST_IDLE;
                        end
                    end else begin
                        d.state = ST_IDLE;
                    end
                end
            end
            ST_CAPTURE: begin
                if (tick) begin
                    d.wr = q.wr + ADDR_W'(1);
                    if (q.wr == q.last) begin
                        d.state = ST_DONE;
                        d.done  = 1'b1;
                    end
                end
            end
            ST_READOUT: begin
                if (q.ph == '0) begin
                    d.ph = PH_W'(1);
                end else if (tx_ready_i) begin
                    if (int'(q.ph) == LF_PHASE) begin
                        d.ph = '0;
                        if (q.rd == q.last) begin
                            d.state = ST_IDLE;
                        end else begin
                            d.rd = q.rd + ADDR_W'(1);
                        end
                    end else begin
                        d.ph = q.ph + PH_W'(1);
                    end
                end
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q        <= '0;
            q.state  <= ST_IDLE;
            q.div    <= DIV_W'(RESET_DIV);
            q.cnt_m1 <= ADDR_W'(RESET_COUNT - 1);
        end else begin
            q <= d;
        end
    end

    // R5: the write address never passes the last requested sample
    p_wr_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_CAPTURE) |-> (q.wr <= q.last));

    // R5: done holds until a dump or arm byte can clear it
    p_done_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !(rx_fire && ((rx_data_i == CH_DUMP) || (rx_data_i == CH_ARM))))
        |=> done_o);

    // R6: an arm byte during capture does not restart the write address
    p_arm_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((q.state == ST_CAPTURE) && rx_fire && !tick) |=> $stable(q.wr));

    // R7: a bad character in a parameter string keeps both settings
    p_cfg_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((q.state == ST_CONFIG) && rx_fire && !is_hex_char(rx_data_i))
        |=> ($stable(q.div) && $stable(q.cnt_m1) && (q.state == ST_IDLE)));

    // R9: a stalled output byte is held
    p_tx_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid_o && !tx_ready_i) |=> (tx_valid_o && $stable(tx_data_o)));

endmodule

// File: tb/la_capture_ctrl_tb.sv
`timescale 1ns/1ps
module la_capture_ctrl_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] probe = 8'h00;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_data = 8'h00;
    logic       tx_ready = 1'b0;
    logic       rx_ready, tx_valid, done;
    logic [7:0] tx_data;

    int unsigned cyc = 0;
    int errors = 0;
    int checks = 0;
    bit finished = 0;

    int unsigned acc_k;
    int unsigned cur_div = 4, cur_cnt = 16;
    int unsigned cap_k, cap_div, cap_cnt;
    bit          stall = 0;
    logic [7:0]  held;
    int          hold_bad;

    always #2 clk = ~clk;

    la_capture_ctrl u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .probe_i    (probe),
        .rx_valid_i (rx_valid),
        .rx_data_i  (rx_data),
        .rx_ready_o (rx_ready),
        .tx_valid_o (tx_valid),
        .tx_data_o  (tx_data),
        .tx_ready_i (tx_ready),
        .done_o     (done)
    );

    function automatic logic [7:0] pat(input int unsigned x);
        int unsigned h;
        h = (x * 157) ^ (x >> 5) ^ (x >> 11);
        return h[7:0];
    endfunction

    function automatic logic [7:0] hexc(input logic [3:0] n);
        if (n < 10) return 8'h30 + 8'(n);
        return 8'h41 + 8'(n) - 8'd10;
    endfunction

    always @(posedge clk) cyc <= cyc + 1;
    always @(negedge clk) probe <= pat(cyc);

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    task automatic chk(input bit ok, input string what, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic send_byte(input logic [7:0] b);
        @(negedge clk);
        rx_valid = 1'b1;
        rx_data  = b;
        acc_k    = cyc;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic send_rate(input int unsigned v);
        send_byte(8'h52);
        for (int i = 7; i >= 0; i--) send_byte(hexc(4'(v >> (4 * i))));
        cur_div = (v < 4) ? 4 : v;
    endtask

    task automatic send_count(input int unsigned m1);
        send_byte(8'h4E);
        for (int i = 2; i >= 0; i--) send_byte(hexc(4'(m1 >> (4 * i))));
        cur_cnt = m1 + 1;
    endtask

    // mode 0: plain, 1: extra arm mid-capture, 2: arm on the final write edge
    task automatic run_capture(input int mode, input string tag);
        int unsigned tgt;
        send_byte(8'h41);
        cap_k   = acc_k;
        cap_div = cur_div;
        cap_cnt = cur_cnt;
        tgt = cap_k + cap_cnt * cap_div;
        chk(done == 1'b0, {"R4 done cleared by arm ", tag}, done, 0);
        if (mode == 1) begin
            repeat (2) @(negedge clk);
            send_byte(8'h41);
        end
        if (mode == 2) begin
            while (cyc < tgt - 1) @(negedge clk);
            send_byte(8'h41);
            chk(done == 1'b1, {"R5 done on final edge ", tag}, done, 1);
            repeat (3 * cap_div) @(negedge clk);
            chk(done == 1'b1 && tx_valid == 1'b0, {"R6 arm on final edge ignored ", tag}, done, 1);
        end else begin
            while (cyc < tgt) @(negedge clk);
            chk(done == 1'b0, {"R5 done not before last sample ", tag}, done, 0);
            @(negedge clk);
            chk(done == 1'b1, {"R5 done at last sample ", tag}, done, 1);
        end
    endtask

    task automatic get_tx(output logic [7:0] b);
        forever begin
            @(negedge clk);
            tx_ready = (($urandom % 4) != 0);
            if (stall && (!tx_valid || tx_data != held)) hold_bad++;
            if (tx_valid && tx_ready) begin
                b = tx_data;
                stall = 0;
                break;
            end
            stall = tx_valid;
            held  = tx_data;
        end
    endtask

    task automatic readback(input string tag);
        logic [7:0] b0, b1, b2, e;
        hold_bad = 0;
        stall = 0;
        send_byte(8'h44);
        chk(rx_ready == 1'b0, {"R9 rx_ready low in dump ", tag}, rx_ready, 0);
        chk(done == 1'b0, {"R8 done cleared by dump ", tag}, done, 0);
        for (int i = 0; i < int'(cap_cnt); i++) begin
            get_tx(b0);
            get_tx(b1);
            get_tx(b2);
            e = pat(cap_k + (i + 1) * cap_div);
            chk(b0 == hexc(e[7:4]) && b1 == hexc(e[3:0]) && b2 == 8'h0A,
                $sformatf("R8 R4 sample %0d %s", i, tag),
                {b0, b1, b2}, {hexc(e[7:4]), hexc(e[3:0]), 8'h0A});
        end
        @(negedge clk);
        tx_ready = 1'b0;
        chk(tx_valid == 1'b0 && rx_ready == 1'b1, {"R8 idle after dump ", tag},
            {tx_valid, rx_ready}, 2'b01);
        chk(hold_bad == 0, {"R9 stalled byte held ", tag}, hold_bad, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog all: actual=timeout expected=completion");
            report();
            $finish;
        end
    end

    initial begin
        int unsigned v, c;
        int mode;
        void'($urandom(32'd4711));
        repeat (4) @(negedge clk);
        chk(done == 1'b0 && tx_valid == 1'b0 && rx_ready == 1'b1, "R1 outputs in reset",
            {done, tx_valid, rx_ready}, 3'b001);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(done == 1'b0 && tx_valid == 1'b0 && rx_ready == 1'b1, "R1 outputs after reset",
            {done, tx_valid, rx_ready}, 3'b001);

        // R8: dump request with nothing captured sends nothing
        send_byte(8'h44);
        repeat (8) begin
            @(negedge clk);
            if (tx_valid) break;
        end
        chk(tx_valid == 1'b0 && rx_ready == 1'b1, "R8 dump ignored without done", tx_valid, 0);

        // R1: defaults, divisor 4 and 16 samples
        run_capture(0, "R1 defaults");
        readback("R1 defaults");

        // R2 R3: new settings, plus an arm byte in mid capture (R6)
        send_rate(7);
        send_count(41);
        run_capture(1, "R2 R3 R6 mid arm");
        readback("R2 R3");

        // R7: broken parameter strings, then a stray character in idle
        send_byte(8'h52);
        send_byte(8'h30);
        send_byte(8'h31);
        send_byte(8'h5A);
        send_byte(8'h4E);
        send_byte(8'h30);
        send_byte(8'h61);
        send_byte(8'h51);
        run_capture(0, "R7 settings kept");
        readback("R7");

        // R2: divisor below minimum is raised to 4; R3: count 1
        send_rate(1);
        send_count(0);
        run_capture(0, "R2 clamp R3 one");
        readback("R2 clamp");

        // R6: arm accepted on the same edge as the final write
        send_rate(5);
        send_count(9);
        run_capture(2, "R6 overlap");
        readback("R6 overlap");

        // random settings
        for (int r = 0; r < 8; r++) begin
            v = 4 + ($urandom % 29);
            c = $urandom % 64;
            if (($urandom % 2) == 0) send_rate(v);
            send_count(c);
            mode = $urandom % 3;
            if (mode == 1 && cur_cnt * cur_div < 12) mode = 0;
            run_capture(mode, $sformatf("R4 random %0d", r));
            readback($sformatf("R8 random %0d", r));
        end

        // R3: full store of 4096 samples
        send_rate(4);
        send_count(12'hFFF);
        run_capture(0, "R3 full");
        readback("R3 full");

        finished = 1;
        report();
        $finish;
    end

endmodule